// File: doc/BRIEF.md
# Three-Port Bit-Slice Register File

This block is a small register file of eight entries with one write port and two read ports. All three ports work in every clock cycle, and each port has its own address. The storage is latch-based and split by clock phase. Each entry is a master latch that is open while the clock is low. It closes on the rising edge and keeps the bit it holds at that moment. Each read port ends in its own slave latch, which opens while the clock is high and holds while the clock is low. Because the latches open on opposite phases, a location can be read and written in the same cycle without a race. The read port shows the old word until the rising edge and the new word after it.

There is no write enable. In every low phase the entry selected by the write address takes the data input. An active-low slave-enable input keeps both slave latches open in both clock phases. A wider word is made by raising the data-width parameter. Every bit lane then acts as an independent slice, and all lanes share the clock, the slave enable and the three addresses. The result is two read words of that width per cycle.

Top module: `tri_port_slice_rf`

## Requirements
- R1: The file has 2^AW entries (AW = 3 by default, so eight). The write address and the two read addresses are independent, and any combination of values, including all three equal, is legal in the same cycle.
- R2: While `clk` is low, the entry selected by `wr_adr` follows `wr_dat`. With the slave enable asserted, a read port addressing that entry shows `wr_dat` during the same low phase.
- R3: At the rising edge of `clk`, the selected entry keeps the value `wr_dat` has at that edge. Every entry not selected by `wr_adr` keeps its contents.
- R4: While `clk` is high, `q_b` equals the entry at `rd_b_adr` and `q_c` equals the entry at `rd_c_adr`. If a read address changes during the high phase, the output follows it.
- R5: While `clk` is low and `slv_en_n` is 1, `q_b` and `q_c` keep the values they had at the falling edge, even when the read addresses or the addressed entries change.
- R6: While `slv_en_n` is 0, both outputs show the entry selected by their read address in both clock phases.
- R7: When the entry being written is also being read, the read port shows the previous contents during the low phase (with `slv_en_n` = 1). It shows the new contents during the high phase that follows the rising edge.
- R8: With DW > 1, each bit lane of every entry is written and read independently of the other lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock: masters open when low, capture on rise; slaves open when high |
| slv_en_n | input | 1 | Active-low override that keeps both output latches open |
| wr_adr | input | AW | Entry written during the low phase |
| wr_dat | input | DW | Write data |
| rd_b_adr | input | AW | Entry selected for read port B |
| rd_c_adr | input | AW | Entry selected for read port C |
| q_b | output | DW | Read port B data |
| q_c | output | DW | Read port C data |

## Verification
Within one cycle, a write to an entry and a read of that same entry can collide. The bench provokes this with directed cycles in which both read addresses equal the write address. The random traffic also produces such cycles, because its addresses are drawn from only eight values. Each collision is judged twice against a bench model that tracks the clock phases. Late in the low phase, the output must still show the older word, or the incoming data when the slave enable is asserted. Early in the high phase, it must show the newly written word.

// File: rtl/tri_port_slice_rf.sv
module tri_port_slice_rf #(
  parameter int DW = 1,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          slv_en_n,
  input  logic [AW-1:0] wr_adr,
  input  logic [DW-1:0] wr_dat,
  input  logic [AW-1:0] rd_b_adr,
  input  logic [AW-1:0] rd_c_adr,
  output logic [DW-1:0] q_b,
  output logic [DW-1:0] q_c
);
  localparam int NE = 1 << AW;

  logic [NE-1:0][DW-1:0] cells;
  logic [DW-1:0] sel_b, sel_c;
  logic slave_open;

  for (genvar e = 0; e < NE; e++) begin : g_master
    logic [DW-1:0] m_q;
    always_latch begin
      if (!clk && wr_adr == AW'(e)) m_q <= wr_dat;
    end
    assign cells[e] = m_q;
  end

  assign sel_b      = cells[rd_b_adr];
  assign sel_c      = cells[rd_c_adr];
  assign slave_open = clk | ~slv_en_n;

  always_latch begin
    if (slave_open) q_b <= sel_b;
  end

  always_latch begin
    if (slave_open) q_c <= sel_c;
  end

  logic                  armed, fell_seen, se_f;
  logic [AW-1:0]         wa_q;
  logic [DW-1:0]         wd_q, qb_f, qc_f;
  logic [NE-1:0][DW-1:0] snap;

  always_ff @(posedge clk) begin
    armed <= 1'b1;
    wa_q  <= wr_adr;
    wd_q  <= wr_dat;
  end

  always_ff @(negedge clk) begin
    fell_seen <= armed;
    snap      <= cells;
    qb_f      <= q_b;
    qc_f      <= q_c;
    se_f      <= slv_en_n;
  end

  a_r3_capture: assert property (@(negedge clk) disable iff (!armed)
    cells[wa_q] == wd_q);

  for (genvar e = 0; e < NE; e++) begin : g_keep
    a_r3_keep_other: assert property (@(posedge clk) disable iff (!fell_seen)
      (wr_adr != AW'(e)) |-> cells[e] == snap[e]);
  end

  a_r4_follow_high: assert property (@(negedge clk) disable iff (!armed)
    q_b == cells[rd_b_adr] && q_c == cells[rd_c_adr]);

  a_r5_hold_low: assert property (@(posedge clk) disable iff (!fell_seen)
    (slv_en_n && se_f) |-> (q_b == qb_f && q_c == qc_f));

  a_r6_transparent: assert property (@(posedge clk) disable iff (!armed)
    !slv_en_n |-> (q_b == cells[rd_b_adr] && q_c == cells[rd_c_adr]));
endmodule

// File: tb/tri_port_slice_rf_test.sv
`timescale 1ns/100ps
module tri_port_slice_rf_test;
  localparam int DW = 4;
  localparam int AW = 3;
  localparam int NE = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          slv_en_n = 1'b1;
  logic [AW-1:0] wr_adr = '0, rd_b_adr = '0, rd_c_adr = '0;
  logic [DW-1:0] wr_dat = '0;
  logic [DW-1:0] q_b, q_c;

  tri_port_slice_rf #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .slv_en_n(slv_en_n), .wr_adr(wr_adr), .wr_dat(wr_dat),
    .rd_b_adr(rd_b_adr), .rd_c_adr(rd_c_adr), .q_b(q_b), .q_c(q_c));

  logic [DW-1:0] model [NE];
  bit   [NE-1:0] written = '0;
  logic [DW-1:0] held_b, held_c;
  bit held_ok = 0, prev_se = 1, done = 0;
  int checks = 0, fails = 0;

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] low_view(logic [AW-1:0] ra, logic [AW-1:0] wa, logic [DW-1:0] d);
    return (ra == wa) ? d : model[ra];
  endfunction

  task automatic cyc(string tag, logic [AW-1:0] wa, logic [DW-1:0] d,
                     logic [AW-1:0] rb, logic [AW-1:0] rc, logic se);
    @(negedge clk);
    #0.5;
    wr_adr = wa; wr_dat = d; rd_b_adr = rb; rd_c_adr = rc; slv_en_n = se;
    #1.5;
    if (!se) begin
      if (written[rb] || rb == wa) chk(tag, "low q_b", q_b, low_view(rb, wa, d));
      if (written[rc] || rc == wa) chk(tag, "low q_c", q_c, low_view(rc, wa, d));
    end else if (prev_se && held_ok) begin
      chk(tag, "hold q_b", q_b, held_b);
      chk(tag, "hold q_c", q_c, held_c);
    end
    @(posedge clk);
    model[wa] = d;
    written[wa] = 1'b1;
    #1;
    if (written[rb]) chk(tag, "high q_b", q_b, model[rb]);
    if (written[rc]) chk(tag, "high q_c", q_c, model[rc]);
    held_b = model[rb]; held_c = model[rc];
    held_ok = written[rb] && written[rc];
    prev_se = se;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: fill every entry, reading back on both ports
    for (int i = 0; i < NE; i++)
      cyc("R1", AW'(i), DW'(i * 3 + 1), AW'(i), AW'(NE - 1 - i), 1'b1);
    for (int i = 0; i < NE; i++)
      cyc("R1", AW'(i), DW'(i * 3 + 1), AW'(i), AW'((i + 3) % NE), 1'b1);
    // R7: write entry 3 while both ports read it
    cyc("R7", 3'd3, 4'hA, 3'd3, 3'd3, 1'b1);
    cyc("R7", 3'd3, 4'h5, 3'd3, 3'd3, 1'b1);
    // R5: addresses and addressed entry change during low, outputs hold
    cyc("R5", 3'd6, 4'hE, 3'd6, 3'd2, 1'b1);
    cyc("R5", 3'd2, 4'h1, 3'd2, 3'd6, 1'b1);
    // R3: keep writing entry 5; other entries must keep contents
    for (int i = 0; i < NE; i++)
      cyc("R3", 3'd5, DW'(i), AW'(i), AW'(NE - 1 - i), 1'b1);
    // R2 / R6: transparent slaves show data flowing through the master
    cyc("R6", 3'd4, 4'h9, 3'd0, 3'd7, 1'b0);
    cyc("R2", 3'd4, 4'h3, 3'd4, 3'd4, 1'b0);
    cyc("R2", 3'd4, 4'hC, 3'd4, 3'd1, 1'b0);
    cyc("R6", 3'd1, 4'h7, 3'd4, 3'd1, 1'b0);
    // R8: lanes independent
    cyc("R8", 3'd0, 4'b1010, 3'd0, 3'd0, 1'b1);
    cyc("R8", 3'd7, 4'b0101, 3'd0, 3'd7, 1'b1);
    cyc("R8", 3'd0, 4'b1000, 3'd0, 3'd7, 1'b1);
    // R4: random mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] wa = AW'($urandom);
      logic [AW-1:0] rb = ($urandom % 4 == 0) ? wa : AW'($urandom);
      logic [AW-1:0] rc = ($urandom % 4 == 0) ? wa : AW'($urandom);
      logic se = ($urandom % 4 != 0);
      cyc("R4", wa, DW'($urandom), rb, rc, se);
    end
    // R4: address change inside the high phase
    cyc("R4", 3'd2, 4'h6, 3'd2, 3'd2, 1'b1);
    rd_b_adr = 3'd5; rd_c_adr = 3'd0;
    #0.5;
    chk("R4", "mid-high q_b", q_b, model[5]);
    chk("R4", "mid-high q_c", q_c, model[0]);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule